// File: doc/BRIEF.md
# Banked GPIO Controller with Masked Writes

This block provides general-purpose I/O pins for a processor subsystem. The pins are grouped into 8-bit ports, and the ports are grouped into modules of four. With the default parameters there are three modules and twelve ports. Software reaches every port through a word-wide register bus. Each port has the following registers:

- pin enable
- output drive enable
- output level
- synchronised input level
- pending interrupt status
- interrupt enable
- interrupt polarity
- a write-only clear strobe

A second copy of the register window is aliased at offset 0x800. A write there updates only the bits selected by a mask that travels in the same data word. Software can therefore set, clear or rewrite a chosen group of bits without a read-modify-write sequence. Input pins pass through a two-flop synchroniser. Enabled interrupts are level sensitive and latch until software clears them. Each module drives one summary interrupt line.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset every register reads 0, `pin_oe` and `pin_out` are all 0, and `irq_summary` is 0.
- R2: A register address is (module × 0x80) + ((port & 3) × 4) + offset, where module = port >> 2. The offsets are: pin enable 0x00, output enable 0x10, output level 0x20, input level 0x30, status 0x40, interrupt enable 0x50, polarity 0x60 and clear 0x70. Writes to the enable, output enable, output level, interrupt enable and polarity registers read back at the same address and touch no other port.
- R3: A write with address bit 11 set (the +0x800 alias) works as follows. Data bits 15:8 form a mask. Each register bit whose mask bit is 1 takes the matching bit of data bits 7:0. Every other bit keeps its value. Mask = value sets bits, and mask with value 0 clears them.
- R4: A plain write (address bit 11 clear) replaces all 8 register bits with data bits 7:0 and ignores data bits 31:8. Reads return the register in bits 7:0 with bits 31:8 zero.
- R5: Port p occupies bits 8p+7..8p of `pin_in`, `pin_out` and `pin_oe`. A pin drives (`pin_oe` = 1, `pin_out` = output level) only when both its pin enable bit and its output enable bit are 1. Otherwise `pin_oe` and `pin_out` are 0 for that pin.
- R6: The input level register shows `pin_in` delayed by two clock edges.
- R7: A status bit is set on the edge after its synchronised input equals its polarity bit (1 = high, 0 = low) while its enable bit is 1. It stays set after the input changes. A disabled bit never sets.
- R8: Writing 1 to a clear-register bit, through either window, clears that status bit on the write edge. If an event for that bit occurs in the same cycle, the bit stays set.
- R9: `irq_summary[m]` is the OR over the four ports of module m of (status AND interrupt enable).
- R10: The following read zero: a module index of 3 or more, any address with bits 10:9 nonzero, and the clear register. Writes to such addresses, and writes to the input level and status registers, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address; bit 11 selects the masked alias |
| bus_wdata | input | 32 | Write data (mask in 15:8, value in 7:0 for alias writes) |
| bus_rdata | output | 32 | Read data; combinational from the address |
| pin_in | input | 96 | Pin input levels, port p in bits 8p+7..8p |
| pin_out | output | 96 | Pin output levels |
| pin_oe | output | 96 | Pin drive enables |
| irq_summary | output | 3 | One summary interrupt per module |

## Verification
Register writes take effect on the write edge. Because pin outputs and read data are combinational from registers, both are checked half a cycle after that edge. A pin change reaches the input register after two edges and a status bit after three, so the bench drives pins on a falling edge and counts falling edges. It samples once one edge short of the due cycle, to see the old value, and again on the due cycle. The clear-versus-event race is forced by holding the pin at its active level while the clear is written. The status must still read set after that write edge.

// File: rtl/gpio_pkg.sv
// Package: shared register selector encoding and address-field layout for the
// banked GPIO controller. Assumes 8-bit ports and a 12-bit byte address.
package gpio_pkg;

    // Register selector, taken from address bits 6:4 (offset / 0x10).
    typedef enum logic [2:0] {
        SEL_PEN  = 3'd0,
        SEL_DEN  = 3'd1,
        SEL_DOUT = 3'd2,
        SEL_DIN  = 3'd3,
        SEL_STAT = 3'd4,
        SEL_IEN  = 3'd5,
        SEL_POL  = 3'd6,
        SEL_CLR  = 3'd7
    } gpio_reg_e;

    // Address field positions; the software-visible map depends on these.
    localparam int ADDR_W    = 12;
    localparam int ALIAS_BIT = 11;
    localparam int LANE_LSB  = 2;
    localparam int LANE_W    = 2;
    localparam int SEL_LSB   = 4;
    localparam int SEL_W     = 3;
    localparam int MOD_LSB   = 7;
    localparam int MOD_W     = 2;
    localparam int GAP_LSB   = 9;
    localparam int GAP_W     = 2;

endpackage

// File: rtl/gpio_sync.sv
// Module: gpio_sync
// Two-flop synchroniser for a bus of asynchronous pin inputs. Assumes each bit
// is independent (no multi-bit coherence is implied).
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1;

    // Shift the pin levels through two capture stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

    // Counts edges since reset so the delay check looks back no further.
    logic [1:0] settle_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)                 settle_cnt <= '0;
        else if (settle_cnt != 2'd2) settle_cnt <= settle_cnt + 2'd1;
    end

    AST_SYNC_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
        (settle_cnt == 2'd2) |-> (q == $past(d, 2))); // R6

endmodule

// File: rtl/gpio_port.sv
// Module: gpio_port
// Register set and level interrupt logic for one GPIO port. Assumes the parent
// has decoded the address, and presents a per-bit write mask (all ones for
// plain writes) together with the new bit values.
module gpio_port
    import gpio_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  gpio_reg_e    wr_sel,
    input  logic [W-1:0] wr_mask,
    input  logic [W-1:0] wr_val,
    input  logic [W-1:0] pin_sync,
    output logic [W-1:0] pen,
    output logic [W-1:0] den,
    output logic [W-1:0] dout,
    output logic [W-1:0] stat,
    output logic [W-1:0] ien,
    output logic [W-1:0] pol,
    output logic         irq
);

    logic [W-1:0] clr_bits;
    logic [W-1:0] evt;

    // Bits to clear this cycle: a clear write strobes the masked value bits.
    always_comb begin
        clr_bits = '0;
        if (wr_en && (wr_sel == SEL_CLR)) clr_bits = wr_mask & wr_val;
    end

    // An enabled bit fires while its synchronised input matches its polarity.
    assign evt = ien & ~(pin_sync ^ pol);

    // Configuration registers with masked update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pen  <= '0;
            den  <= '0;
            dout <= '0;
            ien  <= '0;
            pol  <= '0;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_PEN:  pen  <= (pen  & ~wr_mask) | (wr_val & wr_mask);
                SEL_DEN:  den  <= (den  & ~wr_mask) | (wr_val & wr_mask);
                SEL_DOUT: dout <= (dout & ~wr_mask) | (wr_val & wr_mask);
                SEL_IEN:  ien  <= (ien  & ~wr_mask) | (wr_val & wr_mask);
                SEL_POL:  pol  <= (pol  & ~wr_mask) | (wr_val & wr_mask);
                default: ;
            endcase
        end
    end

    // Pending status: latched events, cleared by strobe, new event wins.
    always_ff @(posedge clk) begin
        if (!rst_n) stat <= '0;
        else        stat <= (stat & ~clr_bits) | evt;
    end

    // Port contribution to the module summary interrupt.
    assign irq = |(stat & ien);

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_bits) |=> ((stat & $past(clr_bits & ~evt)) == '0)); // R8

    AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((stat & $past(evt)) == $past(evt))); // R7

    AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_bits == '0) && (evt == '0)) |=> (stat == $past(stat))); // R7

    AST_MASK_KEEPS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_sel == SEL_DOUT)) |=>
        ((dout & ~$past(wr_mask)) == ($past(dout) & ~$past(wr_mask)))); // R3

endmodule

// File: rtl/gpio_bank_ctrl.sv
// Module: gpio_bank_ctrl
// Top of the banked GPIO controller: decodes the register bus (plain and
// masked-alias windows), instantiates one synchroniser and register set per
// port, muxes read data and merges port interrupts per module. Assumes at most
// four modules of at most four ports, matching the fixed address fields.
module gpio_bank_ctrl
    import gpio_pkg::*;
#(
    parameter int NUM_MODULES   = 3,
    parameter int PORTS_PER_MOD = 4,
    parameter int PORT_W        = 8,
    localparam int NUM_PORTS    = NUM_MODULES * PORTS_PER_MOD,
    localparam int PIN_W        = NUM_PORTS * PORT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [PIN_W-1:0]  pin_in,
    output logic [PIN_W-1:0]  pin_out,
    output logic [PIN_W-1:0]  pin_oe,
    output logic [NUM_MODULES-1:0] irq_summary
);

    logic [MOD_W-1:0]  mod_idx;
    logic [LANE_W-1:0] lane_idx;
    logic [GAP_W-1:0]  gap_bits;
    gpio_reg_e         reg_sel;
    logic              is_alias;
    logic              hit;
    logic [PORT_W-1:0] wmask;
    logic [PORT_W-1:0] wval;
    logic [PORT_W-1:0] rd_byte   [NUM_PORTS];
    logic [NUM_PORTS-1:0] port_irq;
    logic [PORT_W-1:0] rd_sel_byte;

    // Split the byte address into its fields.
    assign mod_idx  = bus_addr[MOD_LSB  +: MOD_W];
    assign lane_idx = bus_addr[LANE_LSB +: LANE_W];
    assign gap_bits = bus_addr[GAP_LSB  +: GAP_W];
    assign reg_sel  = gpio_reg_e'(bus_addr[SEL_LSB +: SEL_W]);
    assign is_alias = bus_addr[ALIAS_BIT];

    // An address is mapped when its module exists and the gap bits are zero.
    assign hit = (int'(mod_idx) < NUM_MODULES) && (int'(lane_idx) < PORTS_PER_MOD)
                 && (gap_bits == '0);

    // Alias writes carry a mask; plain writes update every bit.
    assign wmask = is_alias ? bus_wdata[PORT_W +: PORT_W] : '1;
    assign wval  = bus_wdata[PORT_W-1:0];

    logic unused_bits;
    assign unused_bits = ^{bus_wdata[31:2*PORT_W], bus_addr[LANE_LSB-1:0]};

    for (genvar m = 0; m < NUM_MODULES; m++) begin : g_mod
        for (genvar l = 0; l < PORTS_PER_MOD; l++) begin : g_port
            localparam int P = m * PORTS_PER_MOD + l;
            logic [PORT_W-1:0] syn, pen, den, dout, stat, ien, pol;
            logic              port_we;

            // Write strobe for this port.
            assign port_we = bus_sel && bus_we && hit &&
                             (int'(mod_idx) == m) && (int'(lane_idx) == l);

            gpio_sync #(.W(PORT_W)) u_sync (
                .clk (clk),
                .rst_n (rst_n),
                .d   (pin_in[P*PORT_W +: PORT_W]),
                .q   (syn)
            );

            gpio_port #(.W(PORT_W)) u_port (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_en    (port_we),
                .wr_sel   (reg_sel),
                .wr_mask  (wmask),
                .wr_val   (wval),
                .pin_sync (syn),
                .pen      (pen),
                .den      (den),
                .dout     (dout),
                .stat     (stat),
                .ien      (ien),
                .pol      (pol),
                .irq      (port_irq[P])
            );

            // Drive only pins that are both enabled and output-enabled.
            assign pin_oe [P*PORT_W +: PORT_W] = pen & den;
            assign pin_out[P*PORT_W +: PORT_W] = pen & den & dout;

            // Per-port read value for the selected register.
            always_comb begin
                case (reg_sel)
                    SEL_PEN:  rd_byte[P] = pen;
                    SEL_DEN:  rd_byte[P] = den;
                    SEL_DOUT: rd_byte[P] = dout;
                    SEL_DIN:  rd_byte[P] = syn;
                    SEL_STAT: rd_byte[P] = stat;
                    SEL_IEN:  rd_byte[P] = ien;
                    SEL_POL:  rd_byte[P] = pol;
                    default:  rd_byte[P] = '0;
                endcase
            end
        end

        // Module summary interrupt.
        assign irq_summary[m] = |port_irq[m*PORTS_PER_MOD +: PORTS_PER_MOD];
    end

    // Select the addressed port's read value; unmapped reads give zero.
    always_comb begin
        rd_sel_byte = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (bus_sel && hit &&
                (int'(mod_idx) * PORTS_PER_MOD + int'(lane_idx) == p))
                rd_sel_byte = rd_byte[p];
        end
    end

    assign bus_rdata = {{(32-PORT_W){1'b0}}, rd_sel_byte};

    AST_UNMAPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !hit) |-> (bus_rdata == '0)); // R10

endmodule

// File: tb/gpio_bank_ctrl_bench.sv
// Directed bench for gpio_bank_ctrl: one task per scenario, each checking its
// own results at the cycle they are due.
module gpio_bank_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [95:0] pin_in = '0;
    logic [95:0] pin_out;
    logic [95:0] pin_oe;
    logic [2:0]  irq_summary;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    gpio_bank_ctrl u_gpio_bank_ctrl (
        .clk (clk), .rst_n (rst_n), .bus_sel (bus_sel), .bus_we (bus_we),
        .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .pin_in (pin_in), .pin_out (pin_out), .pin_oe (pin_oe),
        .irq_summary (irq_summary)
    );

    function automatic logic [11:0] ra(int port, int off);
        return 12'(((port >> 2) << 7) + ((port & 3) << 2) + off);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_now(logic [11:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd_now(ra(0, 8'h00), d);  chk("R1 pen", d, 0);
        rd_now(ra(11, 8'h20), d); chk("R1 dout", d, 0);
        rd_now(ra(6, 8'h40), d);  chk("R1 stat", d, 0);
        chk("R1 pin_oe", pin_oe[31:0], 0);
        chk("R1 irq", {29'd0, irq_summary}, 0);
    endtask

    task automatic t_map;
        logic [31:0] d;
        wr(ra(0, 8'h00), 32'h11);
        wr(ra(5, 8'h10), 32'h55);
        wr(ra(11, 8'h50), 32'hB0);
        rd_now(ra(0, 8'h00), d);  chk("R2 port0 pen", d, 32'h11);
        rd_now(ra(5, 8'h10), d);  chk("R2 port5 den", d, 32'h55);
        rd_now(ra(11, 8'h50), d); chk("R2 port11 ien", d, 32'hB0);
        rd_now(ra(1, 8'h00), d);  chk("R2 port1 untouched", d, 0);
        wr(ra(11, 8'h50), 32'h0);
    endtask

    task automatic t_plain_and_mask;
        logic [31:0] d;
        wr(ra(3, 8'h60), 32'hABCD_EF5A);
        rd_now(ra(3, 8'h60), d); chk("R4 upper data ignored", d, 32'h5A);
        wr(ra(5, 8'h20), 32'hF0);
        wr(12'h800 | ra(5, 8'h20), 32'h3C0F);
        rd_now(ra(5, 8'h20), d); chk("R3 masked merge", d, 32'hCC);
        wr(12'h800 | ra(5, 8'h20), 32'h0303);
        rd_now(ra(5, 8'h20), d); chk("R3 set idiom", d, 32'hCF);
        wr(12'h800 | ra(5, 8'h20), 32'h8000);
        rd_now(ra(5, 8'h20), d); chk("R3 clear idiom", d, 32'h4F);
    endtask

    task automatic t_drive;
        wr(ra(2, 8'h00), 32'h0F);
        wr(ra(2, 8'h10), 32'h3C);
        wr(ra(2, 8'h20), 32'hFF);
        chk("R5 pin_oe port2", {24'd0, pin_oe[23:16]}, 32'h0C);
        chk("R5 pin_out port2", {24'd0, pin_out[23:16]}, 32'h0C);
        chk("R5 port5 not driving", {24'd0, pin_out[47:40]}, 0);
    endtask

    task automatic t_sync;
        logic [31:0] d;
        @(negedge clk);
        pin_in[63:56] = 8'hA5;
        step(1);
        rd_now(ra(7, 8'h30), d); chk("R6 one edge not yet", d, 0);
        step(1);
        rd_now(ra(7, 8'h30), d); chk("R6 after two edges", d, 32'hA5);
    endtask

    task automatic t_irq;
        logic [31:0] d;
        wr(ra(9, 8'h60), 32'hFF);
        wr(ra(9, 8'h50), 32'h01);
        @(negedge clk);
        pin_in[79:72] = 8'h05;
        step(2);
        rd_now(ra(9, 8'h40), d); chk("R7 not set after two edges", d, 0);
        step(1);
        rd_now(ra(9, 8'h40), d); chk("R7 set on third edge, disabled bit clear", d, 32'h01);
        chk("R9 module2 summary", {29'd0, irq_summary}, 32'h4);
        pin_in[79:72] = 8'h04;
        step(3);
        rd_now(ra(9, 8'h40), d); chk("R7 latched after input drops", d, 32'h01);
        wr(ra(9, 8'h70), 32'h01);
        rd_now(ra(9, 8'h40), d); chk("R8 clear write", d, 0);
        chk("R9 summary drops", {29'd0, irq_summary}, 0);
        pin_in[79:72] = 8'h05;
        step(3);
        wr(12'h800 | ra(9, 8'h70), 32'h0101);
        rd_now(ra(9, 8'h40), d); chk("R8 event wins over clear", d, 32'h01);
        wr(ra(9, 8'h50), 32'h00);
        chk("R9 needs enable", {29'd0, irq_summary}, 0);
        wr(12'h800 | ra(9, 8'h60), 32'h0200);
        wr(12'h800 | ra(9, 8'h50), 32'h0202);
        step(1);
        rd_now(ra(9, 8'h40), d); chk("R7 low polarity", d, 32'h03);
        chk("R9 summary low level", {29'd0, irq_summary}, 32'h4);
    endtask

    task automatic t_unmapped;
        logic [31:0] d;
        wr(ra(9, 8'h40), 32'h00);
        rd_now(ra(9, 8'h40), d); chk("R10 status write ignored", d, 32'h03);
        wr(ra(7, 8'h30), 32'h00);
        rd_now(ra(7, 8'h30), d); chk("R10 input write ignored", d, 32'hA5);
        wr(12'h180, 32'hFF);
        rd_now(12'h180, d); chk("R10 module 3 reads zero", d, 0);
        rd_now(ra(0, 8'h00), d); chk("R10 module 3 write no effect", d, 32'h11);
        wr(12'h200, 32'hFF);
        rd_now(12'h200, d); chk("R10 gap address reads zero", d, 0);
        rd_now(ra(0, 8'h00), d); chk("R10 gap write no effect", d, 32'h11);
        rd_now(ra(9, 8'h70), d); chk("R10 clear reads zero", d, 0);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset;
        t_map;
        t_plain_and_mask;
        t_drive;
        t_sync;
        t_irq;
        t_unmapped;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule